// File: doc/BRIEF.md
# Multi-Channel Pulse-Width Modulator with Prescaler

This block produces one pulse-width-modulated output per channel from a shared clock. Every channel runs its own period counter, clocked by a divided tick chosen from eight divide ratios. Each period has an active window, bounded by a start count and an end count. Outside that window the channel is in its inactive phase. Each phase drives one of three levels: high, low, or released (output enable deasserted).

Software configures the block through a simple write-only register port. Each channel has two words of timing settings. The first word, holding the window edges, is only staged. The second word, holding the period, levels and divider, commits the staged pair. On a running channel the committed pair takes effect at the next period boundary, so a period in progress is never cut short or stretched. A shared enable register turns channels on and off, either by a direct write or through set and clear aliases.

Top module: `pwm_multi`

## Requirements
- R1: After reset every channel is disabled and its level fields are 0, so every `pwm_oe` bit is 0 and every `pwm_out` bit is 0.
- R2: Bit n of the enable register belongs to channel n. Writing 0x000 loads the register directly. Channel n's window word is at 0x100 + 0x20·n and its period word is at 0x110 + 0x20·n. A write to one channel's words leaves every other channel's outputs unchanged.
- R3: A write to 0x004 sets the enable bits written as 1, and a write to 0x008 clears them. Enable bits written as 0 keep their value in both cases.
- R4: The period word's bits [15:0] give P, the period length in divided ticks. The counter runs 0..P-1 and then restarts at 0. P = 0 behaves as P = 1.
- R5: The window word's bits [15:0] give the start count S and bits [31:16] the end count E. The channel is in its active phase when S ≤ count < E. S ≥ E gives no active phase.
- R6: The period word's bits [17:16] give the active-phase level and bits [19:18] the inactive-phase level. 3 drives high, 2 drives low, and 0 or 1 drives `pwm_oe` low with `pwm_out` low.
- R7: The period word's bits [22:20] select the tick divide ratio. Values 0..7 select 1, 2, 4, 8, 16, 64, 256 and 1024 clock cycles per count.
- R8: A window-word write alone changes no output behaviour. The staged value is kept until a later period-word write commits it.
- R9: On an enabled channel, a committed pair takes effect at the next period boundary. The period in progress completes with the old settings.
- R10: A disabled channel holds its count at 0 and drives its inactive level, and a committed pair applies to it at once. When the channel is enabled, the cycle after the enabling write shows count 0 of a fresh period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per asserted cycle |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 32 | Write data |
| pwm_out | output | NCH | Output level per channel |
| pwm_oe | output | NCH | Output enable per channel; 0 means released |

## Verification
The main function is driven with a table of thirteen settings. These cover every divide ratio, normal and inverted levels, a window starting mid-period, an empty window, an end count past the period, a zero period and released levels. Each run counts high cycles and driven cycles over exactly one period. This distinguishes wrong window edges, wrong divide ratios and wrong level decoding. A cycle-exact trace across a mid-period update tells an update applied at the boundary apart from one applied at once. Windowed counts before and after a window-word-only write show whether the staged value leaks early. Alias writes and writes to another channel's address show that set, clear and channel stride disturb nothing else.

// File: rtl/pwm_pkg.sv
// Package: shared widths, per-channel configuration type and decode helpers
// for the multi-channel PWM. Assumes the period word layout
// [15:0] period, [17:16] active level, [19:18] inactive level, [22:20] divider.
package pwm_pkg;

    localparam int CNT_W     = 16;
    localparam int DIV_W     = 3;
    localparam int LVL_W     = 2;
    localparam int PRE_W     = 10;            // log2 of the largest ratio
    localparam int RATIO_W   = PRE_W + 1;

    // Level codes: 3 high, 2 low, 0/1 released
    localparam logic [LVL_W-1:0] LVL_HIGH = 2'd3;

    typedef struct packed {
        logic [LVL_W-1:0] inact_lvl;
        logic [LVL_W-1:0] act_lvl;
        logic [DIV_W-1:0] div_sel;
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] win_end;
        logic [CNT_W-1:0] win_start;
    } chan_cfg_t;

    // Divide ratio exponent for each divider select value
    function automatic logic [3:0] ratio_log2(input logic [DIV_W-1:0] sel);
        case (sel)
            3'd0: ratio_log2 = 4'd0;
            3'd1: ratio_log2 = 4'd1;
            3'd2: ratio_log2 = 4'd2;
            3'd3: ratio_log2 = 4'd3;
            3'd4: ratio_log2 = 4'd4;
            3'd5: ratio_log2 = 4'd6;
            3'd6: ratio_log2 = 4'd8;
            default: ratio_log2 = 4'd10;
        endcase
    endfunction

    // Build a configuration from a staged window word and a period word
    function automatic chan_cfg_t unpack_cfg(input logic [31:0] win_word,
                                             input logic [31:0] per_word);
        chan_cfg_t c;
        c.win_start = win_word[15:0];
        c.win_end   = win_word[31:16];
        c.period    = per_word[15:0];
        c.act_lvl   = per_word[17:16];
        c.inact_lvl = per_word[19:18];
        c.div_sel   = per_word[22:20];
        return c;
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
// Prescaler: turns the clock into a count tick every 2^k cycles, k chosen by
// the divider select. Assumes div_sel only changes while the prescaler is at
// zero (at a period boundary or while disabled). Held at zero when disabled.
module pwm_prescaler
    import pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_sel,
    output logic             tick
);

    logic [PRE_W-1:0]   pre_q;
    logic [RATIO_W-1:0] ratio;

    // Ratio from the select code
    always_comb begin
        ratio = RATIO_W'(1) << ratio_log2(div_sel);
        tick  = run && ({1'b0, pre_q} == (ratio - RATIO_W'(1)));
    end

    // Prescale counter: clears on tick or when stopped
    always_ff @(posedge clk) begin
        if (!rst_n)        pre_q <= '0;
        else if (!run)     pre_q <= '0;
        else if (tick)     pre_q <= '0;
        else               pre_q <= pre_q + PRE_W'(1);
    end

    // R7: the prescale count stays below the selected ratio
    assert_pre_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> ({1'b0, pre_q} < ratio));

endmodule

// File: rtl/pwm_regif.sv
// Register interface: decodes single-cycle writes into the channel enable
// register (direct, set and clear aliases) and per-channel window/period
// write strobes. Channel words sit on a 0x20-byte stride. Write-only.
module pwm_regif #(
    parameter int NCH    = 4,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    output logic [NCH-1:0]    chan_en,
    output logic [NCH-1:0]    win_wr,
    output logic [NCH-1:0]    per_wr
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(12'h000);
    localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(12'h004);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(12'h008);
    localparam logic [3:0]        CH_PAGE = 4'h1;   // addr[11:8] of channel words
    localparam int                IDX_LSB = 5;      // 0x20 stride
    localparam int                IDX_W   = 3;
    localparam logic [4:0]        OFF_WIN = 5'h00;
    localparam logic [4:0]        OFF_PER = 5'h10;

    logic [NCH-1:0] en_q;
    logic           ctrl_hit, set_hit, clr_hit, page_hit;
    logic [IDX_W-1:0] idx;
    logic [4:0]     off;

    // Address decode of the shared registers and the channel page
    always_comb begin
        ctrl_hit = wr_en && (wr_addr == A_CTRL);
        set_hit  = wr_en && (wr_addr == A_SET);
        clr_hit  = wr_en && (wr_addr == A_CLR);
        page_hit = wr_en && (wr_addr[11:8] == CH_PAGE);
        idx      = wr_addr[IDX_LSB +: IDX_W];
        off      = wr_addr[4:0];
    end

    // Per-channel write strobes
    generate
        for (genvar n = 0; n < NCH; n++) begin : g_strobe
            always_comb begin
                win_wr[n] = page_hit && (idx == IDX_W'(n)) && (off == OFF_WIN);
                per_wr[n] = page_hit && (idx == IDX_W'(n)) && (off == OFF_PER);
            end
        end
    endgenerate

    // Enable register: direct load, set alias, clear alias
    always_ff @(posedge clk) begin
        if (!rst_n)        en_q <= '0;
        else if (ctrl_hit) en_q <= wr_data[NCH-1:0];
        else if (set_hit)  en_q <= en_q | wr_data[NCH-1:0];
        else if (clr_hit)  en_q <= en_q & ~wr_data[NCH-1:0];
    end

    assign chan_en = en_q;

    // R3: a set write never clears a bit
    assert_set_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        set_hit |=> ((chan_en & $past(chan_en)) == $past(chan_en)));
    // R3: a clear write never sets a bit
    assert_clr_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hit |=> ((chan_en & ~$past(chan_en)) == '0));
    // R2: at most one channel word is written per cycle
    assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({win_wr, per_wr}));

endmodule

// File: rtl/pwm_chan.sv
// One PWM channel: stages the window word, commits it with the period word
// into a pending slot, and loads the live settings at a period boundary (or
// at once while disabled). Drives the active or inactive level from the
// period counter. Assumes the window word is written before the period word.
module pwm_chan
    import pwm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  logic        win_wr,
    input  logic        per_wr,
    input  logic [31:0] wr_data,
    output logic        pwm_out,
    output logic        pwm_oe
);

    logic [31:0]      win_stage_q;
    chan_cfg_t        pend_q, live_q;
    logic             pend_v_q;
    logic [CNT_W-1:0] cnt_q, last_cnt;
    logic             tick, boundary, apply, in_win;
    logic [LVL_W-1:0] lvl;

    pwm_prescaler u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (en),
        .div_sel (live_q.div_sel),
        .tick    (tick)
    );

    // Period end detection; a zero period acts as a one-count period
    always_comb begin
        last_cnt = (live_q.period == '0) ? '0 : live_q.period - CNT_W'(1);
        boundary = tick && (cnt_q >= last_cnt);
        apply    = pend_v_q && (!en || boundary);
    end

    // Staging of the window word
    always_ff @(posedge clk) begin
        if (!rst_n)      win_stage_q <= '0;
        else if (win_wr) win_stage_q <= wr_data;
    end

    // Pending slot: filled by a period write, drained into live settings
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q   <= '0;
            pend_v_q <= 1'b0;
        end else if (per_wr) begin
            pend_q   <= unpack_cfg(win_stage_q, wr_data);
            pend_v_q <= 1'b1;
        end else if (apply) begin
            pend_v_q <= 1'b0;
        end
    end

    // Live settings: loaded only when the pending slot is applied
    always_ff @(posedge clk) begin
        if (!rst_n)     live_q <= '0;
        else if (apply) live_q <= pend_q;
    end

    // Period counter: held at zero while disabled, wraps at the boundary
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (!en)      cnt_q <= '0;
        else if (boundary) cnt_q <= '0;
        else if (tick)     cnt_q <= cnt_q + CNT_W'(1);
    end

    // Output level selection from the active window
    always_comb begin
        in_win  = en && (cnt_q >= live_q.win_start) && (cnt_q < live_q.win_end);
        lvl     = in_win ? live_q.act_lvl : live_q.inact_lvl;
        pwm_oe  = lvl[1];
        pwm_out = (lvl == LVL_HIGH);
    end

    // R4: the counter stays inside the live period
    assert_cnt_in_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q.period != '0) |-> (cnt_q < live_q.period));
    // R10: a disabled channel holds its count at zero
    assert_idle_cnt_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt_q == '0));
    // R9: live settings change only at a boundary while running
    assert_live_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !boundary) |=> $stable(live_q));
    // R8: a window write leaves the pending slot untouched
    assert_win_no_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (win_wr && !pend_v_q) |=> !pend_v_q);

endmodule

// File: rtl/pwm_multi.sv
// Top: multi-channel PWM with a shared write port and enable register and
// NCH independent channels, each with shadowed timing and its own prescaler.
// Assumes one register write per cycle and software ordering window, period.
module pwm_multi #(
    parameter int NCH    = 4,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    output logic [NCH-1:0]    pwm_out,
    output logic [NCH-1:0]    pwm_oe
);

    logic [NCH-1:0] chan_en, win_wr, per_wr;

    pwm_regif #(.NCH(NCH), .ADDR_W(ADDR_W)) u_regif (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .chan_en (chan_en),
        .win_wr  (win_wr),
        .per_wr  (per_wr)
    );

    // One channel per enable bit
    generate
        for (genvar n = 0; n < NCH; n++) begin : g_chan
            pwm_chan u_chan (
                .clk     (clk),
                .rst_n   (rst_n),
                .en      (chan_en[n]),
                .win_wr  (win_wr[n]),
                .per_wr  (per_wr[n]),
                .wr_data (wr_data),
                .pwm_out (pwm_out[n]),
                .pwm_oe  (pwm_oe[n])
            );
        end
    endgenerate

    // R6: a high output is always driven
    assert_high_is_driven_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((pwm_out & ~pwm_oe) == '0));

endmodule

// File: tb/pwm_multi_tb.sv
module pwm_multi_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;

    typedef struct packed {
        logic [15:0] s;
        logic [15:0] e;
        logic [15:0] p;
        logic [2:0]  dv;
        logic [1:0]  al;
        logic [1:0]  il;
        logic [15:0] win;
        logic [15:0] hi;
        logic [15:0] oe;
    } vec_t;

    // start, end, period, div, act lvl, inact lvl, window, exp high, exp driven
    localparam vec_t VEC [13] = '{
        '{16'd0, 16'd5,  16'd10, 3'd0, 2'd3, 2'd2, 16'd10,   16'd5,    16'd10},
        '{16'd2, 16'd6,  16'd8,  3'd1, 2'd3, 2'd2, 16'd16,   16'd8,    16'd16},
        '{16'd1, 16'd3,  16'd4,  3'd2, 2'd2, 2'd3, 16'd16,   16'd8,    16'd16},
        '{16'd0, 16'd1,  16'd2,  3'd5, 2'd3, 2'd2, 16'd128,  16'd64,   16'd128},
        '{16'd0, 16'd1,  16'd2,  3'd7, 2'd3, 2'd2, 16'd2048, 16'd1024, 16'd2048},
        '{16'd3, 16'd3,  16'd5,  3'd0, 2'd3, 2'd2, 16'd5,    16'd0,    16'd5},
        '{16'd0, 16'd20, 16'd6,  3'd0, 2'd3, 2'd2, 16'd6,    16'd6,    16'd6},
        '{16'd0, 16'd1,  16'd0,  3'd0, 2'd3, 2'd2, 16'd4,    16'd4,    16'd4},
        '{16'd0, 16'd2,  16'd4,  3'd0, 2'd1, 2'd0, 16'd4,    16'd0,    16'd0},
        '{16'd0, 16'd2,  16'd4,  3'd0, 2'd3, 2'd0, 16'd4,    16'd2,    16'd2},
        '{16'd1, 16'd2,  16'd3,  3'd3, 2'd3, 2'd2, 16'd24,   16'd8,    16'd24},
        '{16'd1, 16'd2,  16'd2,  3'd4, 2'd3, 2'd2, 16'd32,   16'd16,   16'd32},
        '{16'd0, 16'd1,  16'd2,  3'd6, 2'd3, 2'd2, 16'd512,  16'd256,  16'd512}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [11:0]      wr_addr = '0;
    logic [31:0]      wr_data = '0;
    logic [NCH-1:0]   pwm_out, pwm_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    pwm_multi #(.NCH(NCH), .ADDR_W(12)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_out(pwm_out), .pwm_oe(pwm_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [11:0] a_win(input int n);
        return 12'h100 + 12'(n * 32);
    endfunction
    function automatic logic [11:0] a_per(input int n);
        return 12'h110 + 12'(n * 32);
    endfunction
    function automatic logic [31:0] per_word(input logic [15:0] p, input logic [2:0] dv,
                                             input logic [1:0] al, input logic [1:0] il);
        return {9'd0, dv, il, al, p};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One write; returns at the negedge after the write edge
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int hi, oe, exp_b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 oe", 32'(pwm_oe), 0);
        check("R1 out", 32'(pwm_out), 0);

        // R2: program channel 2 only (disabled): only its oe rises
        wr(a_win(2), {16'd4, 16'd0});
        wr(a_per(2), per_word(16'd4, 3'd0, 2'd3, 2'd2));
        @(negedge clk);
        check("R2 ch2 driven, others released", 32'(pwm_oe), 32'h4);
        check("R2 out low", 32'(pwm_out), 0);

        // Table walk on channel 1 (R4 R5 R6 R7 R10)
        foreach (VEC[i]) begin
            wr(12'h008, 32'h2);
            wr(a_win(1), {VEC[i].e, VEC[i].s});
            wr(a_per(1), per_word(VEC[i].p, VEC[i].dv, VEC[i].al, VEC[i].il));
            wr(12'h004, 32'h2);
            hi = 0; oe = 0;
            for (int c = 0; c < int'(VEC[i].win); c++) begin
                if (pwm_oe[1] && pwm_out[1]) hi++;
                if (pwm_oe[1]) oe++;
                @(negedge clk);
            end
            check($sformatf("R5/R7 vec%0d high cycles", i), 32'(hi), 32'(VEC[i].hi));
            check($sformatf("R6/R4 vec%0d driven cycles", i), 32'(oe), 32'(VEC[i].oe));
        end

        // R3: direct load, set and clear aliases on channels 0 and 2
        wr(12'h008, 32'hF);
        wr(a_win(0), {16'd4, 16'd0});
        wr(a_per(0), per_word(16'd4, 3'd0, 2'd3, 2'd2));
        wr(12'h000, 32'h5);
        check("R3 direct load", 32'(pwm_out & 4'h5), 32'h5);
        wr(12'h004, 32'h2);
        check("R3 set keeps 0 and 2", 32'(pwm_out & 4'h5), 32'h5);
        wr(12'h008, 32'h1);
        check("R3 clear only ch0", 32'(pwm_out & 4'h5), 32'h4);
        check("R10 cleared ch0 drives inactive low", 32'(pwm_oe[0]), 1);

        // R9: mid-period update takes effect at the boundary
        wr(12'h008, 32'hF);
        wr(a_win(0), {16'd5, 16'd0});
        wr(a_per(0), per_word(16'd10, 3'd0, 2'd3, 2'd2));
        wr(12'h004, 32'h1);
        for (int c = 0; c < 30; c++) begin
            exp_b = (c < 10) ? int'((c % 10) < 5) : int'((c % 10) < 8);
            check($sformatf("R9 cycle %0d", c), 32'(pwm_out[0]), 32'(exp_b));
            if (c == 2) begin wr_en = 1'b1; wr_addr = a_win(0); wr_data = {16'd8, 16'd0}; end
            else if (c == 3) begin wr_en = 1'b1; wr_addr = a_per(0);
                wr_data = per_word(16'd10, 3'd0, 2'd3, 2'd2); end
            else wr_en = 1'b0;
            @(negedge clk);
        end
        wr_en = 1'b0;

        // R8: window write alone changes nothing until a period write
        wr(a_win(0), {16'd3, 16'd0});
        repeat (20) @(negedge clk);
        hi = 0;
        for (int c = 0; c < 20; c++) begin
            if (pwm_out[0]) hi++;
            @(negedge clk);
        end
        check("R8 staged window not applied", 32'(hi), 16);
        wr(a_per(0), per_word(16'd10, 3'd0, 2'd3, 2'd2));
        repeat (20) @(negedge clk);
        hi = 0;
        for (int c = 0; c < 20; c++) begin
            if (pwm_out[0]) hi++;
            @(negedge clk);
        end
        check("R8 staged window committed", 32'(hi), 6);

        // R10: disabled holds inactive level, re-enable restarts at count 0
        wr(12'h008, 32'h1);
        repeat (5) @(negedge clk);
        check("R10 disabled out", 32'(pwm_out[0]), 0);
        check("R10 disabled oe", 32'(pwm_oe[0]), 1);
        wr(12'h004, 32'h1);
        hi = 0;
        for (int c = 0; c < 3; c++) begin
            if (pwm_out[0]) hi++;
            @(negedge clk);
        end
        check("R10 fresh period after enable", 32'(hi), 3);
        check("R2 ch3 untouched", 32'(pwm_oe[3]), 0);

        finish_run();
    end

endmodule